// File: doc/BRIEF.md
# Serial Receive Buffer with Per-Entry Status

This block sits behind the deserializer of an asynchronous serial receiver. A frame arrives with a strobe, `frame_done`, together with its 8 data bits, an optional ninth bit and a framing-error indication. The block queues frames in a two-slot circular FIFO. Each slot carries its own framing-error flag, data-overrun flag and ninth bit next to the data byte, so the status the host sees always belongs to the frame at the head. The host reads that status on the head outputs first, then pulses `rd_pop` to discard the frame. Each frame can therefore be read only once.

When both slots are full, a finished frame is not dropped. It is held in the receive shift register, which serves as a third level. It moves into the FIFO on the clock after a slot frees. It is lost only if `start_detected` arrives while the FIFO is still full. In that case the overrun flag is set on the newest queued slot, so the host sees the gap exactly where it occurred in the stream. A `frame_done` that arrives while the third level is still occupied is ignored. Driving `rx_enable` low flushes all three levels.

Occupancy is tracked by one state machine with five states:
- `ST_EMPTY`: no frames.
- `ST_ONE`: one slot used.
- `ST_TWO`: both slots used.
- `ST_TWO_HELD`: both slots used and a frame held in the shift register.
- `ST_ONE_HELD`: a slot was freed while a frame is held; the held frame moves in on the next clock.

The transitions are:
- **enqueue**: `ST_EMPTY`→`ST_ONE` and `ST_ONE`→`ST_TWO`.
- **swap**: a push and a pop on the same clock leave the state unchanged.
- **dequeue**: `ST_TWO`→`ST_ONE` and `ST_ONE`→`ST_EMPTY`.
- **stall**: `ST_TWO`→`ST_TWO_HELD`.
- **free**: `ST_TWO_HELD`→`ST_ONE_HELD`.
- **migrate**: `ST_ONE_HELD`→`ST_TWO`, or →`ST_ONE` if a pop happens on the same clock.
- **overrun**: `ST_TWO_HELD`→`ST_TWO`, or →`ST_ONE` if a pop happens on the same clock.
- **flush**: any state →`ST_EMPTY`.

Top module: `rx_frame_buffer`

## Requirements
- R1: `rx_ready` is high exactly when the FIFO holds at least one frame. After reset it is low, and all head outputs read zero while the FIFO is empty.
- R2: Frames leave in arrival order. The head outputs show the oldest frame's data (`rx_data`), ninth bit (`rx_bit9`), framing error (`rx_ferr`) and overrun flag (`rx_ovr`) from the clock after it is queued, without any read.
- R3: A `rd_pop` while `rx_ready` is high removes the head frame at that clock edge. A `rd_pop` while the FIFO is empty changes nothing.
- R4: Each slot keeps its own ninth bit and framing-error flag. Popping one frame does not alter the status of the frame behind it.
- R5: A `frame_done` while both slots are full and no pop occurs puts the frame in the third level. The two queued frames and `rx_ready` are unaffected.
- R6: A held frame enters the FIFO on the clock after a slot frees, behind the frames already queued.
- R7: A `start_detected` while a frame is held and both slots are full discards the held frame. It also sets `rx_ovr` on the newest queued slot, and the head slot's `rx_ovr` stays 0.
- R8: A `start_detected` while a frame is held but a slot is free (the clock after a pop) loses nothing: the held frame migrates.
- R9: With `rx_enable` low the block empties all three levels at the next edge, clears their status, and ignores `frame_done`.
- R10: A `frame_done` and a `rd_pop` on the same clock with both slots full queue the new frame directly, without using the third level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable; low flushes all levels |
| frame_done | input | 1 | One-cycle strobe: a complete frame is on the frame inputs |
| frame_data | input | DATA_W | Data bits of the completed frame |
| frame_bit9 | input | 1 | Ninth data bit of the completed frame |
| frame_ferr | input | 1 | Framing error of the completed frame |
| start_detected | input | 1 | One-cycle strobe: a new start bit was seen |
| rd_pop | input | 1 | Host reads the data; discards the head frame |
| rx_data | output | DATA_W | Head frame data |
| rx_bit9 | output | 1 | Head frame ninth bit |
| rx_ferr | output | 1 | Head frame framing error |
| rx_ovr | output | 1 | Head frame data-overrun flag |
| rx_ready | output | 1 | Receive complete: at least one frame queued |

## Verification
The bench sends a frame while both slots are full and then frees one slot. A design that drops the frame at once, or that moves it too late or out of order, shows the wrong head after the pop. Overrun is provoked both with a full FIFO and on the clock right after a pop. A design that flags the head instead of the newest slot, or that drops a frame that could still migrate, produces a wrong `rx_ovr` or a missing frame. Pops on an empty FIFO, a push coinciding with a pop on a full FIFO, and a flush with all three levels occupied are also covered. A flaw there would show as a phantom frame, a needless stall, or stale status after re-enable.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int ENTRIES = 2;
    localparam int PTR_W   = $clog2(ENTRIES);
    // Entry word layout above the data field
    localparam int OFS_BIT9 = 0;
    localparam int OFS_FERR = 1;
    localparam int OFS_OVR  = 2;
    localparam int STAT_W   = 3;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_ONE,
        ST_TWO,
        ST_TWO_HELD,
        ST_ONE_HELD
    } occ_state_t;
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
    import rxbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_enable,
    input  logic frame_done,
    input  logic start_detected,
    input  logic rd_pop,
    output logic flush,
    output logic push_en,
    output logic push_from_hold,
    output logic pop_en,
    output logic hold_load,
    output logic hold_clear,
    output logic set_ovr
);
    occ_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d        = state_q;
        flush          = 1'b0;
        push_en        = 1'b0;
        push_from_hold = 1'b0;
        pop_en         = 1'b0;
        hold_load      = 1'b0;
        hold_clear     = 1'b0;
        set_ovr        = 1'b0;
        if (!rx_enable) begin
            flush   = 1'b1;
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (frame_done) begin
                        push_en = 1'b1;
                        state_d = ST_ONE;
                    end
                end
                ST_ONE: begin
                    pop_en = rd_pop;
                    if (frame_done) begin
                        push_en = 1'b1;
                        state_d = rd_pop ? ST_ONE : ST_TWO;
                    end else if (rd_pop) begin
                        state_d = ST_EMPTY;
                    end
                end
                ST_TWO: begin
                    pop_en = rd_pop;
                    if (frame_done && rd_pop) begin
                        push_en = 1'b1;
                        state_d = ST_TWO;
                    end else if (frame_done) begin
                        hold_load = 1'b1;
                        state_d   = ST_TWO_HELD;
                    end else if (rd_pop) begin
                        state_d = ST_ONE;
                    end
                end
                ST_TWO_HELD: begin
                    pop_en = rd_pop;
                    if (start_detected) begin
                        set_ovr    = 1'b1;
                        hold_clear = 1'b1;
                        state_d    = rd_pop ? ST_ONE : ST_TWO;
                    end else if (rd_pop) begin
                        state_d = ST_ONE_HELD;
                    end
                end
                ST_ONE_HELD: begin
                    pop_en         = rd_pop;
                    push_en        = 1'b1;
                    push_from_hold = 1'b1;
                    hold_clear     = 1'b1;
                    state_d        = rd_pop ? ST_ONE : ST_TWO;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // R7: overrun is only ever raised from the fully occupied state
    assert_ovr_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |=> (state_q == ST_TWO || state_q == ST_ONE));

    // R6: a held frame never lingers once a slot is free
    assert_migrate_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONE_HELD && rx_enable) |=> (state_q == ST_TWO || state_q == ST_ONE));
endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int EW = DATA_W + STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          load,
    input  logic          clear,
    input  logic [EW-1:0] in_word,
    output logic [EW-1:0] held_word,
    output logic          held_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_word  <= '0;
            held_valid <= 1'b0;
        end else if (flush || clear) begin
            held_word  <= '0;
            held_valid <= 1'b0;
        end else if (load) begin
            held_word  <= in_word;
            held_valid <= 1'b1;
        end
    end

    // R5: the third level is never reloaded while occupied
    assert_no_hold_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !held_valid);
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int EW = DATA_W + STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_en,
    input  logic [EW-1:0] push_word,
    input  logic          pop_en,
    input  logic          set_ovr,
    output logic [EW-1:0] head_word,
    output logic          head_valid
);
    logic [PTR_W-1:0] wr_ptr, rd_ptr, tail_ptr;
    logic [EW-1:0]    slot [ENTRIES];
    logic [ENTRIES-1:0] vld;

    assign tail_ptr = wr_ptr - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_en) wr_ptr <= wr_ptr + 1'b1;
            if (pop_en)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [EW-1:0] word_q;
        logic          vld_q;
        logic          wr_hit, rd_hit, ovr_hit;

        assign wr_hit  = push_en && (wr_ptr == PTR_W'(g));
        assign rd_hit  = pop_en  && (rd_ptr == PTR_W'(g));
        assign ovr_hit = set_ovr && (tail_ptr == PTR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else if (flush) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                if (wr_hit) begin
                    word_q <= push_word;
                    vld_q  <= 1'b1;
                end else begin
                    if (ovr_hit) word_q[DATA_W+OFS_OVR] <= 1'b1;
                    if (rd_hit)  vld_q <= 1'b0;
                end
            end
        end

        assign slot[g] = word_q;
        assign vld[g]  = vld_q;
    end

    assign head_word  = vld[rd_ptr] ? slot[rd_ptr] : '0;
    assign head_valid = |vld;

    // R3: a pop always removes a live entry
    assert_pop_has_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> vld[rd_ptr]);

    // R5: a push without pop never lands on a live entry
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |-> !vld[wr_ptr]);

    // R7: the overrun mark lands on a live entry behind the head
    assert_ovr_on_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |-> (vld[tail_ptr] && tail_ptr != rd_ptr));
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
    import rxbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_bit9,
    input  logic              frame_ferr,
    input  logic              start_detected,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ferr,
    output logic              rx_ovr,
    output logic              rx_ready
);
    localparam int EW = DATA_W + STAT_W;

    logic flush, push_en, push_from_hold, pop_en, hold_load, hold_clear, set_ovr;
    logic held_valid;
    logic [EW-1:0] new_word, held_word, push_word, head_word;

    assign new_word  = {1'b0, frame_ferr, frame_bit9, frame_data};
    assign push_word = push_from_hold ? held_word : new_word;

    rxbuf_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_enable      (rx_enable),
        .frame_done     (frame_done),
        .start_detected (start_detected),
        .rd_pop         (rd_pop),
        .flush          (flush),
        .push_en        (push_en),
        .push_from_hold (push_from_hold),
        .pop_en         (pop_en),
        .hold_load      (hold_load),
        .hold_clear     (hold_clear),
        .set_ovr        (set_ovr)
    );

    rxbuf_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .load       (hold_load),
        .clear      (hold_clear),
        .in_word    (new_word),
        .held_word  (held_word),
        .held_valid (held_valid)
    );

    rxbuf_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push_en    (push_en),
        .push_word  (push_word),
        .pop_en     (pop_en),
        .set_ovr    (set_ovr),
        .head_word  (head_word),
        .head_valid (rx_ready)
    );

    assign rx_data = head_word[DATA_W-1:0];
    assign rx_bit9 = head_word[DATA_W+OFS_BIT9];
    assign rx_ferr = head_word[DATA_W+OFS_FERR];
    assign rx_ovr  = head_word[DATA_W+OFS_OVR];

    // R1: a frame accepted into an idle buffer makes data ready next clock
    assert_ready_after_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frame_done && !rx_ready) |=> rx_ready);

    // R9: disable empties the buffer
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (!rx_ready && !held_valid));

    // R7: an overrun never empties the queue
    assert_ovr_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovr |=> rx_ready);

    // R1: empty buffer presents a zero head
    assert_empty_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (rx_data == '0 && !rx_bit9 && !rx_ferr && !rx_ovr));
endmodule

// File: tb/rx_frame_buffer_bench.sv
module rx_frame_buffer_bench;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_enable = 1'b0;
    logic frame_done = 1'b0;
    logic [DW-1:0] frame_data = '0;
    logic frame_bit9 = 1'b0;
    logic frame_ferr = 1'b0;
    logic start_detected = 1'b0;
    logic rd_pop = 1'b0;
    logic [DW-1:0] rx_data;
    logic rx_bit9, rx_ferr, rx_ovr, rx_ready;

    always #4 clk = ~clk; // 125 MHz

    rx_frame_buffer #(.DATA_W(DW)) u_rx_frame_buffer (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .frame_done(frame_done), .frame_data(frame_data),
        .frame_bit9(frame_bit9), .frame_ferr(frame_ferr),
        .start_detected(start_detected), .rd_pop(rd_pop),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ferr(rx_ferr),
        .rx_ovr(rx_ovr), .rx_ready(rx_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model: word = {ovr, ferr, bit9, data[7:0]}
    logic [10:0] q[$];
    logic        m_held = 1'b0;
    logic [10:0] m_hword = '0;

    always @(posedge clk) begin
        if (!rst_n || !rx_enable) begin
            q.delete();
            m_held = 1'b0;
        end else begin
            int c;
            bit p;
            c = q.size();
            p = rd_pop && (c > 0);
            if (m_held && c < 2) begin
                if (p) void'(q.pop_front());
                q.push_back(m_hword);
                m_held = 1'b0;
            end else if (m_held) begin
                if (start_detected) begin
                    q[c-1][10] = 1'b1;
                    m_held = 1'b0;
                end
                if (p) void'(q.pop_front());
            end else begin
                if (p) void'(q.pop_front());
                if (frame_done) begin
                    if (q.size() < 2) q.push_back({1'b0, frame_ferr, frame_bit9, frame_data});
                    else begin
                        m_held = 1'b1;
                        m_hword = {1'b0, frame_ferr, frame_bit9, frame_data};
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [10:0] exp_w;
            logic        exp_r;
            exp_r = (q.size() > 0);
            exp_w = exp_r ? q[0] : '0;
            checks++;
            if (rx_ready !== exp_r) begin
                errors++;
                $display("FAIL R1 model rx_ready actual=%0b expected=%0b", rx_ready, exp_r);
            end
            checks++;
            if ({rx_ovr, rx_ferr, rx_bit9, rx_data} !== exp_w) begin
                errors++;
                $display("FAIL R2 model head actual=%h expected=%h",
                         {rx_ovr, rx_ferr, rx_bit9, rx_data}, exp_w);
            end
        end
    end

    task automatic step(input bit fd, input logic [7:0] d, input bit b9, input bit fe,
                        input bit sd, input bit pop);
        @(negedge clk);
        frame_done = fd; frame_data = d; frame_bit9 = b9; frame_ferr = fe;
        start_detected = sd; rd_pop = pop;
        @(negedge clk);
        frame_done = 1'b0; start_detected = 1'b0; rd_pop = 1'b0;
    endtask

    // Sampled one half-cycle after the edge that follows stimulus
    task automatic expect_head(input string tag, input bit r, input logic [10:0] w);
        checks++;
        if (rx_ready !== r || {rx_ovr, rx_ferr, rx_bit9, rx_data} !== w) begin
            errors++;
            $display("FAIL %s actual ready=%0b head=%h expected ready=%0b head=%h",
                     tag, rx_ready, {rx_ovr, rx_ferr, rx_bit9, rx_data}, r, w);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        expect_head("R1 reset state", 1'b0, 11'h000);
        rst_n = 1'b1; rx_enable = 1'b1;

        // R2 / R4: queue two frames with distinct status
        step(1, 8'h5A, 1, 0, 0, 0);
        expect_head("R2 first frame visible", 1'b1, 11'h15A);
        step(1, 8'h3C, 0, 1, 0, 0);
        expect_head("R2 head unchanged by second", 1'b1, 11'h15A);
        // R5: third frame held
        step(1, 8'h81, 1, 0, 0, 0);
        expect_head("R5 held frame keeps head", 1'b1, 11'h15A);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R4 second frame status", 1'b1, 11'h23C);
        step(0, 0, 0, 0, 0, 0); // migrate cycle
        step(0, 0, 0, 0, 0, 1);
        expect_head("R6 held frame migrated", 1'b1, 11'h181);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R3 empty after pops", 1'b0, 11'h000);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R3 pop on empty ignored", 1'b0, 11'h000);

        // R7: overrun flags the newest slot
        step(1, 8'h11, 0, 0, 0, 0);
        step(1, 8'h22, 0, 0, 0, 0);
        step(1, 8'h33, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        expect_head("R7 head ovr clear", 1'b1, 11'h011);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R7 tail ovr set", 1'b1, 11'h422);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R7 held frame discarded", 1'b0, 11'h000);

        // R8: start right after a pop loses nothing
        step(1, 8'h44, 0, 0, 0, 0);
        step(1, 8'h55, 0, 0, 0, 0);
        step(1, 8'h66, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1, 0);
        expect_head("R8 head after pop", 1'b1, 11'h055);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R8 held frame kept", 1'b1, 11'h266);
        step(0, 0, 0, 0, 0, 1);

        // R10: push and pop together on a full FIFO
        step(1, 8'h77, 0, 0, 0, 0);
        step(1, 8'h88, 0, 0, 0, 0);
        step(1, 8'h99, 1, 0, 0, 1);
        expect_head("R10 swap head", 1'b1, 11'h088);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R10 new frame queued", 1'b1, 11'h199);
        step(0, 0, 0, 0, 0, 1);
        expect_head("R10 no stall", 1'b0, 11'h000);

        // R9: flush with all three levels full
        step(1, 8'hA1, 0, 1, 0, 0);
        step(1, 8'hA2, 0, 0, 0, 0);
        step(1, 8'hA3, 0, 0, 0, 0);
        @(negedge clk); rx_enable = 1'b0; frame_done = 1'b1; frame_data = 8'hEE;
        @(negedge clk); frame_done = 1'b0;
        expect_head("R9 flushed while disabled", 1'b0, 11'h000);
        rx_enable = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        expect_head("R9 nothing revived", 1'b0, 11'h000);

        // Mixed stimulus against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame_done = lfsr[0] & lfsr[1];
            frame_data = lfsr[11:4];
            frame_bit9 = lfsr[2];
            frame_ferr = lfsr[3] & lfsr[5];
            start_detected = lfsr[6] & lfsr[7];
            rd_pop = lfsr[8] & lfsr[9] & lfsr[12];
            rx_enable = !(lfsr[13] & lfsr[14] & lfsr[15] & lfsr[10]);
        end
        @(negedge clk);
        frame_done = 1'b0; start_detected = 1'b0; rd_pop = 1'b0; rx_enable = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule